// File: doc/BRIEF.md
# Dynamic Address Assignment Sequencer

This block is the controller side of the I3C dynamic address assignment flow, run against a single target on the two-wire bus. A one-cycle start pulse launches a single transaction. The transaction opens with a START and sends the broadcast header with a write bit. The target acknowledges, and the block follows with the assign-all-addresses broadcast command. It then issues a repeated START and sends the broadcast header with a read bit. After the target acknowledges again, it shifts in the target's 64-bit identity. The block then writes the chosen 7-bit dynamic address with a parity bit, checks the target's acknowledge and closes with a STOP.

The block drives SCL directly. SDA is open-drain: the block asserts an output-enable to pull the line low and reads the line back on a separate input. The bus clock comes from the system clock. Every bus bit is a slot of four quarters, and each quarter lasts `QTR_CYC` system cycles. SCL is low for the first two quarters and high for the last two. A one-cycle done pulse marks the end of the transaction, whether it succeeded or failed. An error flag reports a missing acknowledge. The identity is split into a 48-bit ID and two 8-bit characteristic bytes.

Top module: `daa_sequencer`

## Requirements
- R1: After reset, and whenever no transaction is running, SCL is high, SDA is released, and done and error are low.
- R2: A transaction opens with a START, where SDA falls while SCL stays high. The first eight bits sent after it are 0x7E (MSB first) followed by a 0 read/write bit, so the byte on the wire is 0xFC.
- R3: In each acknowledge slot the block releases SDA. An acknowledge is SDA sampled low while SCL is high.
- R4: After the first acknowledge, the block sends the command byte 0x07 MSB first, then an odd-parity bit. For 0x07 that bit is 0, so the 9-bit field is 0x00E.
- R5: After the command, the block issues a repeated START and then sends 0x7E with a 1 read/write bit, so the byte on the wire is 0xFD.
- R6: After the second acknowledge, the block samples 64 target bits MSB first. The first 48 appear on `pid_o`, the next 8 on `bcr_o` and the last 8 on `dcr_o`. All three hold until the next accepted start and are cleared when it is accepted.
- R7: After the identity, the block sends the dynamic address MSB first, then one bit that makes the 8-bit field's count of ones odd.
- R8: A successful transaction ends with a STOP and a done pulse exactly one cycle long. The pulse comes 103 bit slots, that is 103*4*QTR_CYC cycles, after the start is accepted, with the error flag low.
- R9: A NACK at either header acknowledge sets the error flag and jumps straight to STOP. The done pulse then comes after 11 slots (first header) or 30 slots (second header), and the identity outputs stay cleared.
- R10: A NACK at the address acknowledge sets the error flag. Done still comes after 103 slots, and the captured identity is kept.
- R11: SDA changes while SCL is high only for the START, the repeated START and the STOP. That gives three such changes per transaction, or two when the first header is not acknowledged.
- R12: A start pulse during a running transaction is ignored. Neither the timing nor the address sent changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to run the flow |
| dyn_addr_i | input | 7 | Dynamic address to assign, taken at start |
| pid_o | output | PID_W | Captured 48-bit target ID |
| bcr_o | output | BCR_W | Captured first characteristic byte |
| dcr_o | output | DCR_W | Captured second characteristic byte |
| done_o | output | 1 | One-cycle pulse at transaction end |
| err_o | output | 1 | Set on a missing acknowledge, cleared at next start |
| scl_o | output | 1 | Bus clock |
| sda_oe_o | output | 1 | High pulls SDA low |
| sda_i | input | 1 | SDA line level |

## Verification
The done pulse is due a fixed number of clock edges after the start is taken: 103, 11 or 30 slots times 4*QTR_CYC, depending on where the target withholds its acknowledge. The bench counts edges from the accepting edge and compares the count exactly. Outputs are sampled on falling clock edges. A bus monitor compares each transmitted field against a queue as soon as the SCL rise that completes that field occurs. The identity outputs and the error flag are read in the same falling-edge sample where done is first seen.

// File: rtl/daa_pkg.sv
package daa_pkg;
  typedef enum logic [3:0] {
    PH_IDLE, PH_START, PH_HDRW, PH_ACK1, PH_CCC, PH_RSTART,
    PH_HDRR, PH_ACK2, PH_ID, PH_ADDR, PH_ACK3, PH_STOP
  } phase_e;

  localparam int unsigned DA_W       = 7;
  localparam logic [6:0]  BCAST_ADDR = 7'h7E;
  localparam logic [7:0]  CMD_ENTDAA = 8'h07;
endpackage

// File: rtl/daa_qtick.sv
module daa_qtick #(
  parameter int unsigned QTR_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  output logic       tick_o,
  output logic [1:0] qtr_o
);
  localparam int unsigned CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      qtr_o <= 2'd0;
    end else if (!run_i) begin
      cnt_q <= '0;
      qtr_o <= 2'd0;
    end else if (tick_o) begin
      cnt_q <= '0;
      qtr_o <= qtr_o + 2'd1;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/daa_shift_cap.sv
module daa_shift_cap #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_o <= '0;
    else if (clr_i)   data_o <= '0;
    else if (shift_i) data_o <= {data_o[W-2:0], bit_i};
  end

  AST_CAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !clr_i) |=> $stable(data_o)); // R6
endmodule

// File: rtl/daa_sequencer.sv
module daa_sequencer
  import daa_pkg::*;
#(
  parameter int unsigned QTR_CYC = 4,
  parameter int unsigned PID_W   = 48,
  parameter int unsigned BCR_W   = 8,
  parameter int unsigned DCR_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DA_W-1:0]  dyn_addr_i,
  output logic [PID_W-1:0] pid_o,
  output logic [BCR_W-1:0] bcr_o,
  output logic [DCR_W-1:0] dcr_o,
  output logic             done_o,
  output logic             err_o,
  output logic             scl_o,
  output logic             sda_oe_o,
  input  logic             sda_i
);
  localparam int unsigned ID_W  = PID_W + BCR_W + DCR_W;
  localparam int unsigned IDX_W = ($clog2(ID_W) > 4) ? $clog2(ID_W) : 4;
  localparam logic [7:0] HDR_WR = {BCAST_ADDR, 1'b0};
  localparam logic [7:0] HDR_RD = {BCAST_ADDR, 1'b1};
  localparam logic [8:0] CCC_WORD = {CMD_ENTDAA, ~^CMD_ENTDAA};

  phase_e           phase_q;
  logic [IDX_W-1:0] bit_q;
  logic [DA_W-1:0]  addr_q;
  logic             nack_q, err_q, done_q;
  logic             scl_q, oe_q, spec_q;
  logic             scl_c, oe_c, spec_c;
  logic             tick, busy, accept, samp, slot_end, tx_bit;
  logic [1:0]       qtr;
  logic [ID_W-1:0]  id_w;
  logic [DA_W:0]    addr_word;

  assign busy      = (phase_q != PH_IDLE);
  assign accept    = start_i && !busy;
  assign samp      = tick && (qtr == 2'd2);
  assign slot_end  = tick && (qtr == 2'd3);
  assign addr_word = {addr_q, ~^addr_q};

  daa_qtick #(.QTR_CYC(QTR_CYC)) u_qtick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .tick_o (tick),
    .qtr_o  (qtr)
  );

  daa_shift_cap #(.W(ID_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept),
    .shift_i (samp && (phase_q == PH_ID)),
    .bit_i   (sda_i),
    .data_o  (id_w)
  );

  assign pid_o = id_w[ID_W-1 -: PID_W];
  assign bcr_o = id_w[DCR_W +: BCR_W];
  assign dcr_o = id_w[DCR_W-1:0];

  always_comb begin
    case (phase_q)
      PH_HDRW: tx_bit = HDR_WR[bit_q[2:0]];
      PH_HDRR: tx_bit = HDR_RD[bit_q[2:0]];
      PH_CCC:  tx_bit = CCC_WORD[bit_q[3:0]];
      PH_ADDR: tx_bit = addr_word[bit_q[2:0]];
      default: tx_bit = 1'b1;
    endcase
  end

  // quarter 0 holds SDA so it never moves on the SCL falling edge
  always_comb begin
    scl_c  = 1'b1;
    oe_c   = 1'b0;
    spec_c = 1'b0;
    case (phase_q)
      PH_IDLE: ;
      PH_START: begin
        oe_c   = qtr[1];
        spec_c = 1'b1;
      end
      PH_RSTART: begin
        scl_c  = qtr[1];
        oe_c   = (qtr == 2'd0) ? oe_q : (qtr == 2'd3);
        spec_c = 1'b1;
      end
      PH_STOP: begin
        scl_c  = qtr[1];
        oe_c   = (qtr == 2'd0) ? oe_q : (qtr != 2'd3);
        spec_c = 1'b1;
      end
      PH_HDRW, PH_CCC, PH_HDRR, PH_ADDR: begin
        scl_c = qtr[1];
        oe_c  = (qtr == 2'd0) ? oe_q : !tx_bit;
      end
      default: begin
        scl_c = qtr[1];
        oe_c  = (qtr == 2'd0) ? oe_q : 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      addr_q  <= '0;
      nack_q  <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      scl_q   <= 1'b1;
      oe_q    <= 1'b0;
      spec_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      scl_q  <= scl_c;
      oe_q   <= oe_c;
      spec_q <= spec_c;
      if (accept) begin
        phase_q <= PH_START;
        addr_q  <= dyn_addr_i;
        err_q   <= 1'b0;
        bit_q   <= '0;
      end
      if (samp && (phase_q == PH_ACK1 || phase_q == PH_ACK2 || phase_q == PH_ACK3))
        nack_q <= sda_i;
      if (slot_end) begin
        case (phase_q)
          PH_START: begin
            phase_q <= PH_HDRW;
            bit_q   <= IDX_W'(7);
          end
          PH_HDRW: begin
            if (bit_q == '0) phase_q <= PH_ACK1;
            else             bit_q   <= bit_q - IDX_W'(1);
          end
          PH_ACK1: begin
            if (nack_q) begin
              err_q   <= 1'b1;
              phase_q <= PH_STOP;
            end else begin
              phase_q <= PH_CCC;
              bit_q   <= IDX_W'(8);
            end
          end
          PH_CCC: begin
            if (bit_q == '0) phase_q <= PH_RSTART;
            else             bit_q   <= bit_q - IDX_W'(1);
          end
          PH_RSTART: begin
            phase_q <= PH_HDRR;
            bit_q   <= IDX_W'(7);
          end
          PH_HDRR: begin
            if (bit_q == '0) phase_q <= PH_ACK2;
            else             bit_q   <= bit_q - IDX_W'(1);
          end
          PH_ACK2: begin
            if (nack_q) begin
              err_q   <= 1'b1;
              phase_q <= PH_STOP;
            end else begin
              phase_q <= PH_ID;
              bit_q   <= IDX_W'(ID_W - 1);
            end
          end
          PH_ID: begin
            if (bit_q == '0) begin
              phase_q <= PH_ADDR;
              bit_q   <= IDX_W'(7);
            end else begin
              bit_q <= bit_q - IDX_W'(1);
            end
          end
          PH_ADDR: begin
            if (bit_q == '0) phase_q <= PH_ACK3;
            else             bit_q   <= bit_q - IDX_W'(1);
          end
          PH_ACK3: begin
            if (nack_q) err_q <= 1'b1;
            phase_q <= PH_STOP;
          end
          PH_STOP: begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign scl_o    = scl_q;
  assign sda_oe_o = oe_q;
  assign done_o   = done_q;
  assign err_o    = err_q;

  AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_q && $past(scl_q) && !spec_q && !$past(spec_q)) |-> $stable(oe_q)); // R11
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R8
  AST_IDLE_BUS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE) |-> (scl_q && !oe_q)); // R1
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !accept) |=> err_q); // R9
endmodule

// File: tb/tb_daa_sequencer.sv
`timescale 1ns/1ps
module tb_daa_sequencer;
  localparam int QTR  = 4;
  localparam int SLOT = 4 * QTR;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  daddr = 7'd0;
  logic [47:0] pid;
  logic [7:0]  bcr, dcr;
  logic        done, err, scl, oe;
  logic        dev_pull = 1'b0;
  wire         sda = !(oe || dev_pull);

  always #10 clk = ~clk;

  daa_sequencer #(.QTR_CYC(QTR)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dyn_addr_i(daddr),
    .pid_o(pid), .bcr_o(bcr), .dcr_o(dcr), .done_o(done), .err_o(err),
    .scl_o(scl), .sda_oe_o(oe), .sda_i(sda)
  );

  int checks = 0;
  int errors = 0;
  logic [63:0] dev_id = '0;
  int nack_at = 0;
  logic [8:0] exp_q[$];
  string exp_req[$];
  int high_chg = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic field_cmp(input logic [8:0] act);
    if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected field", {55'd0, act}, 64'd0);
    else begin
      logic [8:0] e;
      string r;
      e = exp_q.pop_front();
      r = exp_req.pop_front();
      chk(act == e, r, "bus field", {55'd0, act}, {55'd0, e});
    end
  endtask

  function automatic logic want_pull(input int p);
    if (p == 8)   return nack_at != 1;   // R3 header ack
    if (p == 27)  return nack_at != 2;
    if (p == 100) return nack_at != 3;
    if (p >= 28 && p <= 91) return !dev_id[63 - (p - 28)];
    return 1'b0;
  endfunction

  // target model and monitor: counts SCL rises after START
  initial begin
    bit in_frame;
    int pos;
    logic [8:0] shr;
    logic ps, pd;
    in_frame = 0; pos = 0; shr = '0; ps = 1'b1; pd = 1'b1;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        in_frame = 0; pos = 0; dev_pull = 1'b0; ps = 1'b1; pd = 1'b1;
      end else begin
        logic s, d;
        s = scl; d = sda;
        if (s && ps && d != pd) begin
          high_chg++;
          if (!d && !in_frame) begin in_frame = 1; pos = 0; end
          else if (d) begin in_frame = 0; pos = 0; dev_pull = 1'b0; end
        end else if (s && !ps && in_frame) begin
          shr = {shr[7:0], d};
          if (pos == 7 || pos == 26 || pos == 99) field_cmp({1'b0, shr[7:0]});
          else if (pos == 17) field_cmp(shr);
          pos++;
        end else if (!s && ps && in_frame) begin
          dev_pull = want_pull(pos);
        end
        ps = s; pd = d;
      end
    end
  end

  task automatic run(input logic [6:0] a, input logic [63:0] id, input int nk,
                     input int slots, input bit dbl);
    int hc0;
    int cyc;
    string rq;
    rq = (nk == 0) ? (dbl ? "R12" : "R8") : (nk == 3) ? "R10" : "R9";
    dev_id = id;
    nack_at = nk;
    exp_q.push_back(9'h0FC); exp_req.push_back("R2");
    if (nk != 1) begin
      exp_q.push_back(9'h00E); exp_req.push_back("R4");
      exp_q.push_back(9'h0FD); exp_req.push_back("R5");
    end
    if (nk != 1 && nk != 2) begin
      exp_q.push_back({1'b0, a, ~^a}); exp_req.push_back(dbl ? "R12" : "R7");
    end
    hc0 = high_chg;
    @(negedge clk); start = 1'b1; daddr = a;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (1) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      start = dbl && (cyc == 50);
      if (dbl && cyc == 50) daddr = ~a;
      if (done || cyc > 4000) break;
    end
    start = 1'b0;
    chk(done, rq, "done seen", {63'd0, done}, 64'd1);
    chk(cyc == slots * SLOT, rq, "done cycle", cyc, slots * SLOT);
    chk(err == (nk != 0), (nk == 3) ? "R10" : (nk == 0) ? "R8" : "R9", "error flag",
        {63'd0, err}, {63'd0, (nk != 0)});
    chk(scl && !oe, "R1", "bus free at done", {62'd0, scl, oe}, 64'd2);
    if (nk == 0 || nk == 3) begin
      chk(pid == id[63:16], "R6", "pid", {16'd0, pid}, {16'd0, id[63:16]});
      chk(bcr == id[15:8], "R6", "bcr", {56'd0, bcr}, {56'd0, id[15:8]});
      chk(dcr == id[7:0], "R6", "dcr", {56'd0, dcr}, {56'd0, id[7:0]});
    end else begin
      chk({pid, bcr, dcr} == 64'd0, "R9", "identity cleared", {pid, bcr, dcr}, 64'd0);
    end
    chk(exp_q.size() == 0, "R5", "fields pending", exp_q.size(), 0);
    chk(high_chg - hc0 == ((nk == 1) ? 2 : 3), "R11", "SDA changes with SCL high",
        high_chg - hc0, (nk == 1) ? 2 : 3);
    @(negedge clk);
    chk(!done, "R8", "done one cycle", {63'd0, done}, 64'd0);
    exp_q.delete();
    exp_req.delete();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scl && !oe, "R1", "reset bus", {62'd0, scl, oe}, 64'd2);
    chk(!done && !err, "R1", "reset flags", {62'd0, done, err}, 64'd0);
    chk({pid, bcr, dcr} == 64'd0, "R1", "reset identity", {pid, bcr, dcr}, 64'd0);
    run(7'h2B, 64'hA5C3_0F12_3456_7E81, 0, 103, 1'b0);
    run(7'h50, 64'h0123_4567_89AB_CDEF, 0, 103, 1'b1);
    run(7'h11, 64'hFFFF_0000_1234_5678, 1, 11, 1'b0);
    run(7'h22, 64'h8000_0000_0000_0001, 2, 30, 1'b0);
    run(7'h7F, 64'h5A5A_C3C3_0F0F_99E7, 3, 103, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule